// File: doc/BRIEF.md
# Two-Group Priority ADC Scan Sequencer

This block walks an analog-to-digital converter through two sets of input channels. A high-priority set (group A) and a low-priority set (group B) are each chosen by an 8-bit enable mask. A scan starts on a hardware trigger for its group, or on a software start for group A. During a scan the block issues one conversion at a time, in ascending channel order, and waits for the converter's done pulse before it issues the next. When a group's scan finishes, the block emits a one-cycle scan-end pulse for that group.

A priority mode lets a group A trigger cut a running group B scan short. The conversion already in flight finishes, its result is abandoned, and group A runs at once. If the rescan option is set, group B then runs again from its lowest enabled channel. A single-channel mode replaces the group A mask with one channel number held in a 5-bit field, so group A converts that channel alone. The converter, the storage of results and the interrupt logic all sit outside this block.

Top module: `adc_grp_scan_seq`

## Requirements
- R1: `reg_sel` selects the register: 0 is the group A mask, 1 is the group B mask, 2 is control. In a mask register, bit n enables channel n for bits 7..0, and bits 15..8 always read as 0. Control bits 15..9 read as 0. After reset every register reads 0.
- R2: While a scan is active, control bit 0 reads 1 and every register write is ignored. This covers both masks and the mode bits.
- R3: Enabled channels are converted in ascending order. `conv_start` is a one-cycle pulse in the cycle after the trigger. Each following pulse comes in the cycle after the `conv_done` for the previous conversion.
- R4: A scan-end pulse (`scan_end_a` or `scan_end_b`) lasts one cycle. It is raised in the cycle after the `conv_done` of the group's last conversion.
- R5: A trigger for a group whose mask is empty raises that group's scan-end in the next cycle, with no conversion.
- R6: When priority mode (control bit 1) is 0, triggers that arrive while a scan is active are ignored. A control write with bit 0 set, made while idle, starts a group A scan.
- R7: When priority mode is 1, a group A trigger during a group B scan ends that scan. Group A's first conversion is issued in the cycle after the `conv_done` of the conversion in flight. The stopped scan raises no `scan_end_b`.
- R8: When priority mode and rescan (control bit 2) are both 1, group B scans again after the pre-empting group A scan ends. The rescan starts from its lowest enabled channel and raises `scan_end_b` when it completes.
- R9: When priority mode is 1 and rescan is 0, the stopped group B scan is dropped, and the block goes idle after group A.
- R10: When single-channel mode (control bit 3) is 1, group A converts only the channel held in control bits 8..4, whatever the group A mask holds.
- R11: When priority mode is 1, a control write with bit 0 set starts no scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selected for the write |
| reg_wdata | input | 16 | Write data |
| rd_sel | input | 2 | Register selected for readback |
| rd_data | output | 16 | Readback data (combinational) |
| trig_a | input | 1 | Group A hardware trigger |
| trig_b | input | 1 | Group B hardware trigger |
| conv_done | input | 1 | Converter done pulse |
| conv_ch | output | 5 | Channel to convert |
| conv_start | output | 1 | Conversion start pulse |
| scan_end_a | output | 1 | Group A scan complete |
| scan_end_b | output | 1 | Group B scan complete |

## Verification
The scan function is tried with several input patterns:
- A sparse mask (channels 0, 2, 5 and 7) separates true ascending order and done-paced spacing from a plain counter that steps through every channel.
- An empty mask separates an immediate scan-end from a stall.
- A group B scan pre-empted on its first channel is run with rescan on and with rescan off. Together the two runs separate a restart from the lowest channel, a resume from the interrupted channel, and a drop.
- Single-channel mode is run with a channel above the mask width and with a channel inside it, which shows that the mask is truly bypassed.
- Writes made during a scan, triggers that arrive while busy, and a software start in priority mode are each followed by a readback or an output count, to show that they had no effect.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_state_e;
  typedef enum logic {GRP_A, GRP_B} grp_e;

  localparam logic [1:0] SEL_MASK_A = 2'd0;
  localparam logic [1:0] SEL_MASK_B = 2'd1;
  localparam logic [1:0] SEL_CTRL   = 2'd2;

  localparam int CTRL_START  = 0;
  localparam int CTRL_PRIO   = 1;
  localparam int CTRL_RESCAN = 2;
  localparam int CTRL_SINGLE = 3;
  localparam int CTRL_CH_LSB = 4;

  // index of the single set bit of a one-hot vector (0 when none is set)
  function automatic int unsigned onehot_idx(input logic [63:0] oh);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 64; i++) begin
      if (oh[i]) r = r | i;
    end
    return r;
  endfunction

  // mask loaded for group A: a single channel, or the mask widened to the scan width
  function automatic logic [63:0] group_a_load(input logic single, input int unsigned ch,
                                               input logic [63:0] mask);
    return single ? (64'd1 << ch) : mask;
  endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 5,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [1:0]        rd_sel,
  input  logic              busy,
  output logic [REG_W-1:0]  rd_data,
  output logic [NUM_CH-1:0] mask_a,
  output logic [NUM_CH-1:0] mask_b,
  output logic              prio,
  output logic              rescan,
  output logic              single,
  output logic [CH_W-1:0]   single_ch,
  output logic              sw_go
);
  localparam int CTRL_TOP = CTRL_CH_LSB + CH_W;

  logic wr_ok;
  logic unused_wdata;

  assign wr_ok        = reg_wr && !busy;
  assign sw_go        = wr_ok && (reg_sel == SEL_CTRL) && reg_wdata[CTRL_START]
                        && !reg_wdata[CTRL_PRIO];
  assign unused_wdata = ^reg_wdata[REG_W-1:CTRL_TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_a    <= '0;
      mask_b    <= '0;
      prio      <= 1'b0;
      rescan    <= 1'b0;
      single    <= 1'b0;
      single_ch <= '0;
    end else if (wr_ok) begin
      case (reg_sel)
        SEL_MASK_A: mask_a <= reg_wdata[NUM_CH-1:0];
        SEL_MASK_B: mask_b <= reg_wdata[NUM_CH-1:0];
        SEL_CTRL: begin
          prio      <= reg_wdata[CTRL_PRIO];
          rescan    <= reg_wdata[CTRL_RESCAN];
          single    <= reg_wdata[CTRL_SINGLE];
          single_ch <= reg_wdata[CTRL_TOP-1:CTRL_CH_LSB];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_MASK_A: rd_data = REG_W'(mask_a);
      SEL_MASK_B: rd_data = REG_W'(mask_b);
      SEL_CTRL:   rd_data = REG_W'({single_ch, single, rescan, prio, busy});
      default:    rd_data = '0;
    endcase
  end

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && busy) |=> ($stable(mask_a) && $stable(mask_b) && $stable(prio)));

  // R11
  prio_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_go |=> !prio);
endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick
  import adc_seq_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = 5
) (
  input  logic [W-1:0]     req,
  output logic [W-1:0]     first_oh,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  logic [W:0] below;

  assign below[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_chain
    assign below[i+1]  = below[i] | req[i];
    assign first_oh[i] = req[i] & ~below[i];
  end

  assign any = below[W];
  assign idx = IDX_W'(onehot_idx(64'(first_oh)));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_a,
  input  logic              trig_b,
  input  logic              sw_go,
  input  logic              conv_done,
  input  logic              prio,
  input  logic              rescan,
  input  logic              single,
  input  logic [CH_W-1:0]   single_ch,
  input  logic [NUM_CH-1:0] mask_a,
  input  logic [NUM_CH-1:0] mask_b,
  output logic              busy,
  output logic [CH_W-1:0]   conv_ch,
  output logic              conv_start,
  output logic              scan_end_a,
  output logic              scan_end_b
);
  localparam int SCAN_W = 1 << CH_W;

  seq_state_e        state_q, state_n;
  grp_e              grp_q, grp_n;
  logic [SCAN_W-1:0] scan_q, scan_n;
  logic              abort_q, abort_n, resume_q, resume_n;
  logic [SCAN_W-1:0] first_oh;
  logic              scan_any, abort_now, load_scan;
  logic [SCAN_W-1:0] load_a, load_b;

  adc_seq_pick #(.W(SCAN_W), .IDX_W(CH_W)) u_pick (
    .req(scan_q), .first_oh(first_oh), .idx(conv_ch), .any(scan_any)
  );

  assign load_a    = SCAN_W'(group_a_load(single, 32'(single_ch), 64'(mask_a)));
  assign load_b    = SCAN_W'(mask_b);
  assign abort_now = abort_q || (prio && trig_a && grp_q == GRP_B && state_q != ST_IDLE);

  assign busy       = state_q != ST_IDLE;
  assign conv_start = state_q == ST_ISSUE && scan_any;
  assign scan_end_a = state_q == ST_ISSUE && !scan_any && grp_q == GRP_A;
  assign scan_end_b = state_q == ST_ISSUE && !scan_any && grp_q == GRP_B;

  always_comb begin
    state_n   = state_q;
    grp_n     = grp_q;
    scan_n    = scan_q;
    abort_n   = abort_q;
    resume_n  = resume_q;
    load_scan = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (trig_a || sw_go) begin
          grp_n = GRP_A; scan_n = load_a; resume_n = 1'b0;
          state_n = ST_ISSUE; load_scan = 1'b1;
        end else if (trig_b) begin
          grp_n = GRP_B; scan_n = load_b; resume_n = 1'b0;
          state_n = ST_ISSUE; load_scan = 1'b1;
        end
      end
      ST_ISSUE: begin
        if (scan_any) begin
          scan_n  = scan_q & ~first_oh;
          abort_n = (grp_q == GRP_B) && abort_now;
          state_n = ST_WAIT;
        end else if (grp_q == GRP_B && abort_now) begin
          // B ended on its own in the same cycle a pre-empt arrived: run A, nothing to resume
          grp_n = GRP_A; scan_n = load_a; resume_n = 1'b0; abort_n = 1'b0;
          load_scan = 1'b1;
        end else if (grp_q == GRP_A && resume_q) begin
          grp_n = GRP_B; scan_n = load_b; resume_n = 1'b0;
          load_scan = 1'b1;
        end else begin
          state_n = ST_IDLE;
        end
      end
      ST_WAIT: begin
        abort_n = (grp_q == GRP_B) && abort_now;
        if (conv_done) begin
          state_n = ST_ISSUE;
          if (grp_q == GRP_B && abort_now) begin
            grp_n = GRP_A; scan_n = load_a; resume_n = rescan; abort_n = 1'b0;
            load_scan = 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      grp_q    <= GRP_A;
      scan_q   <= '0;
      abort_q  <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      grp_q    <= grp_n;
      scan_q   <= scan_n;
      abort_q  <= abort_n;
      resume_q <= resume_n;
    end
  end

  // tracking for the ordering property
  logic [CH_W-1:0] last_ch_q;
  logic            fresh_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ch_q <= '0;
      fresh_q   <= 1'b1;
    end else if (load_scan) begin
      fresh_q <= 1'b1;
    end else if (conv_start) begin
      last_ch_q <= conv_ch;
      fresh_q   <= 1'b0;
    end
  end

  // R3
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !fresh_q) |-> (conv_ch > last_ch_q));

  // R3
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R4
  end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_start, scan_end_a, scan_end_b}));

  // R5
  empty_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && trig_b && !trig_a && !sw_go && mask_b == '0) |=> scan_end_b);

  // R7
  preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prio && state_q == ST_WAIT && grp_q == GRP_B && trig_a && conv_done)
      |=> (grp_q == GRP_A && !scan_end_b));
endmodule

// File: rtl/adc_grp_scan_seq.sv
module adc_grp_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 5,
  parameter int REG_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [1:0]       rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             trig_a,
  input  logic             trig_b,
  input  logic             conv_done,
  output logic [CH_W-1:0]  conv_ch,
  output logic             conv_start,
  output logic             scan_end_a,
  output logic             scan_end_b
);
  logic [NUM_CH-1:0] mask_a, mask_b;
  logic              prio, rescan, single, sw_go, busy;
  logic [CH_W-1:0]   single_ch;

  adc_seq_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rd_sel(rd_sel), .busy(busy), .rd_data(rd_data), .mask_a(mask_a), .mask_b(mask_b),
    .prio(prio), .rescan(rescan), .single(single), .single_ch(single_ch), .sw_go(sw_go)
  );

  adc_seq_fsm #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .trig_a(trig_a), .trig_b(trig_b), .sw_go(sw_go),
    .conv_done(conv_done), .prio(prio), .rescan(rescan), .single(single),
    .single_ch(single_ch), .mask_a(mask_a), .mask_b(mask_b), .busy(busy),
    .conv_ch(conv_ch), .conv_start(conv_start), .scan_end_a(scan_end_a),
    .scan_end_b(scan_end_b)
  );
endmodule

// File: tb/tb_adc_grp_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_grp_scan_seq;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [15:0] rd_data;
  logic        trig_a = 1'b0, trig_b = 1'b0, conv_done = 1'b0;
  logic [4:0]  conv_ch;
  logic        conv_start, scan_end_a, scan_end_b;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, n_conv = 0, n_end_a = 0, n_end_b = 0, overlap = 0, last_start = 0, end_a_cyc = 0;
  int ch_log[64];
  int gap_log[64];

  always #2 clk = ~clk;

  adc_grp_scan_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .trig_a(trig_a), .trig_b(trig_b),
    .conv_done(conv_done), .conv_ch(conv_ch), .conv_start(conv_start),
    .scan_end_a(scan_end_a), .scan_end_b(scan_end_b)
  );

  // converter model and output monitor
  initial begin
    int cnt;
    logic dn;
    cnt = 0;
    forever begin
      @(negedge clk);
      cyc++;
      dn = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) dn = 1'b1;
      end
      if (conv_start) begin
        if (cnt != 0) overlap++;
        if (n_conv < 64) begin
          ch_log[n_conv]  = int'(conv_ch);
          gap_log[n_conv] = cyc - last_start;
        end
        last_start = cyc;
        n_conv++;
        cnt = LAT;
      end
      if (scan_end_a) begin n_end_a++; end_a_cyc = cyc; end
      if (scan_end_b) n_end_b++;
      conv_done = dn;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] d);
    rd_sel = sel;
    #1;
    d = rd_data;
  endtask

  task automatic pulse(input bit grp_b);
    @(negedge clk);
    if (grp_b) trig_b = 1'b1; else trig_a = 1'b1;
    @(negedge clk);
    trig_a = 1'b0; trig_b = 1'b0;
  endtask

  task automatic clear_log();
    n_conv = 0; n_end_a = 0; n_end_b = 0; overlap = 0;
  endtask

  task automatic wait_idle(input string req);
    logic [15:0] d;
    bit done;
    done = 0;
    for (int i = 0; i < 400 && !done; i++) begin
      @(negedge clk);
      rd(2'd2, d);
      if (!d[0]) done = 1;
    end
    if (!done) check({req, " idle timeout"}, 0, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_list(input string req, input int n, input int exp[8]);
    check({req, " conversion count"}, n_conv, n);
    for (int i = 0; i < n && i < n_conv; i++) check({req, " channel order"}, ch_log[i], exp[i]);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); check("R1 reset mask A", int'(d), 0);
    rd(2'd1, d); check("R1 reset mask B", int'(d), 0);
    rd(2'd2, d); check("R1 reset control", int'(d), 0);
    check("R1 reset conv_start", int'(conv_start), 0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(2'd0, 16'hFFA5); rd(2'd0, d); check("R1 mask A reserved bits", int'(d), 'h00A5);
    wr(2'd1, 16'h5A3C); rd(2'd1, d); check("R1 mask B reserved bits", int'(d), 'h003C);
    wr(2'd2, 16'hFE04); rd(2'd2, d); check("R1 control reserved bits", int'(d), 'h0004);
    wr(2'd2, 16'h0000);
  endtask

  task automatic t_scan_a();
    clear_log();
    wr(2'd0, 16'h00A5);
    pulse(0);
    #1;
    check("R3 first start one cycle after trigger", int'(conv_start), 1);
    check("R3 first channel", int'(conv_ch), 0);
    wait_idle("R3");
    check_list("R3", 4, '{0, 2, 5, 7, 0, 0, 0, 0});
    for (int i = 1; i < 4; i++) check("R3 start spacing after done", gap_log[i], LAT + 1);
    check("R3 single conversion in flight", overlap, 0);
    check("R4 end A count", n_end_a, 1);
    check("R4 end A one cycle after last done", end_a_cyc - last_start, LAT + 1);
    check("R4 no end B", n_end_b, 0);
  endtask

  task automatic t_busy_write();
    logic [15:0] d;
    clear_log();
    pulse(0);
    rd(2'd2, d); check("R2 busy flag during scan", int'(d[0]), 1);
    wr(2'd0, 16'h000F);
    wr(2'd2, 16'h0002);
    wait_idle("R2");
    rd(2'd0, d); check("R2 mask write during scan ignored", int'(d), 'h00A5);
    rd(2'd2, d); check("R2 control write during scan ignored", int'(d), 0);
    check("R2 scan unaffected", n_conv, 4);
  endtask

  task automatic t_empty();
    clear_log();
    wr(2'd1, 16'h0000);
    pulse(1);
    #1;
    check("R5 empty B ends next cycle", int'(scan_end_b), 1);
    check("R5 empty B no start", int'(conv_start), 0);
    wait_idle("R5");
    check("R5 empty B no conversions", n_conv, 0);
    check("R5 empty B one end", n_end_b, 1);
  endtask

  task automatic t_nonprio();
    clear_log();
    wr(2'd0, 16'h0003);
    wr(2'd1, 16'h00F0);
    pulse(0);
    pulse(1);
    pulse(0);
    wait_idle("R6");
    check_list("R6 busy triggers ignored", 2, '{0, 1, 0, 0, 0, 0, 0, 0});
    check("R6 no end B", n_end_b, 0);
    check("R6 one end A", n_end_a, 1);
    clear_log();
    wr(2'd2, 16'h0001);
    #1;
    check("R6 software start issues", int'(conv_start), 1);
    wait_idle("R6");
    check_list("R6 software start scan", 2, '{0, 1, 0, 0, 0, 0, 0, 0});
  endtask

  task automatic t_preempt(input bit resume);
    logic [15:0] d;
    clear_log();
    wr(2'd0, 16'h0003);
    wr(2'd1, 16'h00F0);
    wr(2'd2, resume ? 16'h0006 : 16'h0002);
    pulse(1);
    pulse(0);
    wait_idle(resume ? "R8" : "R9");
    if (resume) begin
      check_list("R8 rescan from lowest", 7, '{4, 0, 1, 4, 5, 6, 7, 0});
      check("R8 end B after rescan", n_end_b, 1);
      check("R8 end A", n_end_a, 1);
      check("R7 in-flight done before A start", gap_log[1], LAT + 1);
    end else begin
      check_list("R9 dropped B", 3, '{4, 0, 1, 0, 0, 0, 0, 0});
      check("R7 no end for stopped B", n_end_b, 0);
      check("R9 end A", n_end_a, 1);
      rd(2'd2, d); check("R9 idle after A", int'(d[0]), 0);
    end
    check("R7 single conversion in flight", overlap, 0);
  endtask

  task automatic t_prio_sw();
    logic [15:0] d;
    clear_log();
    wr(2'd2, 16'h0002);
    wr(2'd2, 16'h0003);
    repeat (10) @(negedge clk);
    check("R11 software start ignored", n_conv, 0);
    check("R11 no scan end", n_end_a, 0);
    rd(2'd2, d); check("R11 still idle", int'(d[0]), 0);
  endtask

  task automatic t_single();
    logic [15:0] d;
    clear_log();
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'h0138);
    rd(2'd2, d); check("R10 control readback", int'(d), 'h0138);
    pulse(0);
    wait_idle("R10");
    check_list("R10 channel 19 only", 1, '{19, 0, 0, 0, 0, 0, 0, 0});
    clear_log();
    wr(2'd2, 16'h0068);
    pulse(0);
    wait_idle("R10");
    check_list("R10 channel 6 only", 1, '{6, 0, 0, 0, 0, 0, 0, 0});
    check("R10 end A", n_end_a, 1);
    wr(2'd2, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_scan_a();
    t_busy_write();
    t_empty();
    t_nonprio();
    t_preempt(1);
    t_preempt(0);
    t_prio_sw();
    wr(2'd2, 16'h0000);
    t_single();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule